// File: doc/BRIEF.md
# Dual-Mode Serial Register Slave

This block gives a host access to an external byte-wide register file over one of two serial links. A static mode input selects the link: a four-wire SPI slave (active-low select, serial clock, data in, data out with an output enable) or a two-wire I2C target. Both links share one address pointer, and the pointer names the register that the next data byte reads or writes. All serial pins are brought into the system clock domain through two-flop synchronisers. Their edges are then detected in that domain, so the serial clocks must run several times slower than the system clock.

On the I2C side, the 7-bit target address comes from a pre-decoded three-level strap code. Until the strap is frozen, the slave compares against the live code. The code is captured on the eighth SCL rising edge of the second address phase that matches. After that, changes on the strap have no effect. The slave acknowledges only its own address. On a write, the first data byte loads the pointer. Later bytes write the register the pointer names and advance it by one. A read starts at the current pointer and advances it for every byte sent.

Top module: `sri_top`

## Requirements
- R1: With `use_i2c` low, an SPI frame is the span with `spi_csn` low. Data-in bits are taken on `spi_sclk` rising edges, MSB first, in 8-bit bytes. In the first byte, bit 7 selects the direction (1 = read, 0 = write) and bits 6:0 load the pointer. The pointer is shared with the I2C side.
- R2: In an SPI write frame, each byte after the command is written to the register at the pointer (`reg_we` pulse with `reg_addr`/`reg_wdata`). The pointer then increments by one, wrapping at its width.
- R3: In an SPI read frame, the byte at the pointer is fetched (`reg_re` pulse, pointer +1) after the command byte and after every later byte. It leaves on `spi_miso` MSB first, and each bit changes on a falling `spi_sclk` edge.
- R4: `spi_miso_oe` is high while an SPI frame is open in SPI mode. It is low within three clock cycles after `spi_csn` rises.
- R5: `addr_pin` code 0 selects I2C address 0x48, code 1 selects 0x4A, and codes 2 and 3 select 0x4B. The R/W bit is the LSB of the address byte (1 = read).
- R6: The slave drives `i2c_sda_low` for the ninth-clock ACK only when the address matches. On a mismatch, SDA stays released until the next START. SDA never changes while SCL stays high.
- R7: In an I2C write, the first data byte loads the pointer. Each later byte writes the register at the pointer and increments the pointer. Every byte of an addressed write is acknowledged.
- R8: In an I2C read, bytes come from the current pointer MSB first, and the pointer increments per byte. The master ACK continues the read and a NACK ends it. The pointer keeps its value across transactions.
- R9: Before the strap is frozen, the slave compares against the live `addr_pin` code. The code is frozen on the eighth SCL rising edge of the second matching address phase. Later changes of `addr_pin` are ignored.
- R10: A falling SDA while SCL is high is a START and restarts address reception, including a repeated START inside a transaction. A rising SDA while SCL is high is a STOP and returns the slave to idle.
- R11: After reset, `reg_addr` is 0, no strobe is active and both data outputs are released.
- R12: The interface not selected by `use_i2c` is ignored: it neither acknowledges, drives data nor touches the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_i2c | input | 1 | 1 selects the I2C link, 0 the SPI link |
| spi_csn | input | 1 | SPI select, active low |
| spi_sclk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | SPI data in |
| spi_miso | output | 1 | SPI data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| i2c_scl | input | 1 | I2C clock line |
| i2c_sda | input | 1 | I2C data line as seen on the bus |
| i2c_sda_low | output | 1 | 1 pulls the SDA line low |
| addr_pin | input | 2 | Decoded strap code: 0 low, 1 open, 2 high |
| reg_addr | output | PTR_W | Register file address (the pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read-fetch strobe |
| reg_rdata | input | 8 | Register file read data at `reg_addr` |

## Verification
Two events can coincide. On the eighth SCL rise of an address byte, the target match and the freezing of the strap code happen in the same cycle. The bench provokes this by moving the strap between the first and second matching transactions. It then judges the result from the ACK/NACK pattern of later addresses under a third strap value. The second pair is the SPI command byte's pointer load and the first read fetch. These are held a cycle apart, and the bench judges them by checking that the first byte returned is the one at the newly written pointer rather than the old one.

// File: rtl/sri_pkg.sv
package sri_pkg;

  typedef struct packed {
    logic       set;
    logic [7:0] val;
    logic       wr;
    logic [7:0] wdata;
    logic       rd;
  } ptr_req_t;

  typedef enum logic [2:0] {
    I2C_IDLE, I2C_ADDR, I2C_AACK, I2C_WR, I2C_WACK, I2C_RD, I2C_MACK
  } i2c_st_t;

  function automatic logic [6:0] strap_to_addr(input logic [1:0] code);
    case (code)
      2'd0:    strap_to_addr = 7'h48;
      2'd1:    strap_to_addr = 7'h4A;
      default: strap_to_addr = 7'h4B;
    endcase
  endfunction

endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
  parameter int          N   = 1,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {2{RST[g]}};
      else        ff <= {ff[0], d[g]};
    end
    assign q[g] = ff[1];
  end
endmodule

// File: rtl/sri_ptr.sv
module sri_ptr
  import sri_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ptr_req_t         req,
  output logic [PTR_W-1:0] ptr
);
  logic             adv;
  logic [PTR_W-1:0] load_val;

  assign adv      = (req.wr | req.rd) & ~req.set;
  assign load_val = PTR_W'(req.val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (req.set) ptr <= load_val;
    else if (adv)     ptr <= ptr + PTR_W'(1);
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr == $past(ptr) + PTR_W'(1));

  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req.set |=> ptr == $past(load_val));
endmodule

// File: rtl/sri_spi.sv
module sri_spi
  import sri_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       csn_s,
  input  logic       sclk_s,
  input  logic       mosi_s,
  input  logic [7:0] rdata,
  output ptr_req_t   req,
  output logic       miso,
  output logic       miso_oe
);
  logic       sclk_q, first, rd_mode, load_pend, miso_q, oe_q;
  logic [6:0] in_sr;
  logic [2:0] bit_cnt;
  logic [7:0] tx_sr, byte_val;
  logic       act, rise, fall, byte_done;

  assign act       = en & ~csn_s;
  assign rise      = act & sclk_s & ~sclk_q;
  assign fall      = act & ~sclk_s & sclk_q;
  assign byte_done = rise & (bit_cnt == 3'd7);
  assign byte_val  = {in_sr, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; first <= 1'b1; rd_mode <= 1'b0; load_pend <= 1'b0;
      miso_q <= 1'b0; oe_q <= 1'b0; in_sr <= '0; bit_cnt <= '0; tx_sr <= '0;
    end else begin
      sclk_q    <= sclk_s;
      oe_q      <= act;
      load_pend <= 1'b0;
      if (!act) begin
        bit_cnt <= '0;
        first   <= 1'b1;
        rd_mode <= 1'b0;
      end else begin
        if (rise) begin
          in_sr   <= byte_val[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          first <= 1'b0;
          if (first) rd_mode <= byte_val[7];
          load_pend <= first ? byte_val[7] : rd_mode;
        end
        if (load_pend) begin
          tx_sr <= rdata;
        end else if (fall) begin
          miso_q <= tx_sr[7];
          tx_sr  <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    req       = '0;
    req.set   = byte_done & first;
    req.val   = byte_val;
    req.wr    = byte_done & ~first & ~rd_mode;
    req.wdata = byte_val;
    req.rd    = load_pend & act;
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;

  assert_hiz_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s || !en) |=> !miso_oe);

  assert_fetch_not_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_pend |-> !fall);
endmodule

// File: rtl/sri_alock.sv
module sri_alock
  import sri_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pin_code,
  input  logic       match_evt,
  output logic [6:0] my_addr
);
  logic       seen, locked;
  logic [1:0] lat_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; locked <= 1'b0; lat_code <= '0;
    end else if (match_evt) begin
      if (!seen) seen <= 1'b1;
      else if (!locked) begin
        locked   <= 1'b1;
        lat_code <= pin_code;
      end
    end
  end

  assign my_addr = strap_to_addr(locked ? lat_code : pin_code);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(lat_code));

  assert_lock_after_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(seen) && $past(match_evt));
endmodule

// File: rtl/sri_i2c.sv
module sri_i2c
  import sri_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [7:0] rdata,
  input  logic [6:0] my_addr,
  output ptr_req_t   req,
  output logic       match_evt,
  output logic       sda_low
);
  i2c_st_t    st;
  logic       scl_q, sda_q, rw, first, hit, mack_ok, drive;
  logic [3:0] cnt;
  logic [7:0] sr, tx, shifted;
  logic       start, stop, rise, fall, ld, wbyte;

  assign start     = en & scl_s & scl_q & sda_q & ~sda_s;
  assign stop      = en & scl_s & scl_q & ~sda_q & sda_s;
  assign rise      = en & scl_s & ~scl_q;
  assign fall      = en & ~scl_s & scl_q;
  assign shifted   = {sr[6:0], sda_s};
  assign match_evt = rise & (st == I2C_ADDR) & (cnt == 4'd7) & (shifted[7:1] == my_addr);
  assign ld        = fall & (((st == I2C_AACK) & rw) | ((st == I2C_MACK) & mack_ok));
  assign wbyte     = rise & (st == I2C_WR) & (cnt == 4'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= I2C_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; cnt <= '0; sr <= '0; tx <= '0;
      rw <= 1'b0; first <= 1'b0; hit <= 1'b0; mack_ok <= 1'b0; drive <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (!en) begin
        st <= I2C_IDLE; drive <= 1'b0;
      end else if (start) begin
        st <= I2C_ADDR; cnt <= '0; drive <= 1'b0; hit <= 1'b0;
      end else if (stop) begin
        st <= I2C_IDLE; drive <= 1'b0;
      end else begin
        if (rise && (st == I2C_ADDR || st == I2C_WR)) begin
          sr  <= shifted;
          cnt <= cnt + 4'd1;
        end
        if (rise && st == I2C_RD) cnt <= cnt + 4'd1;
        if (rise && st == I2C_ADDR && cnt == 4'd7) hit <= match_evt;
        if (rise && st == I2C_MACK) mack_ok <= ~sda_s;
        if (ld) begin
          tx    <= {rdata[6:0], 1'b0};
          drive <= ~rdata[7];
          st    <= I2C_RD;
          cnt   <= '0;
        end else if (fall) begin
          case (st)
            I2C_ADDR: if (cnt == 4'd8) begin
              if (hit) begin drive <= 1'b1; rw <= sr[0]; st <= I2C_AACK; end
              else st <= I2C_IDLE;
            end
            I2C_AACK: begin drive <= 1'b0; st <= I2C_WR; cnt <= '0; first <= 1'b1; end
            I2C_WR:   if (cnt == 4'd8) begin drive <= 1'b1; st <= I2C_WACK; first <= 1'b0; end
            I2C_WACK: begin drive <= 1'b0; st <= I2C_WR; cnt <= '0; end
            I2C_RD:   if (cnt == 4'd8) begin drive <= 1'b0; st <= I2C_MACK; end
                      else begin drive <= ~tx[7]; tx <= {tx[6:0], 1'b0}; end
            I2C_MACK: st <= I2C_IDLE;
            default:  ;
          endcase
        end
      end
    end
  end

  always_comb begin
    req       = '0;
    req.set   = wbyte & first;
    req.val   = shifted;
    req.wr    = wbyte & ~first;
    req.wdata = shifted;
    req.rd    = ld;
  end

  assign sda_low = drive;

  assert_sda_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(drive));

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_low);
endmodule

// File: rtl/sri_top.sv
module sri_top
  import sri_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_i2c,
  input  logic             spi_csn,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  input  logic             i2c_scl,
  input  logic             i2c_sda,
  output logic             i2c_sda_low,
  input  logic [1:0]       addr_pin,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  output logic             reg_re,
  input  logic [7:0]       reg_rdata
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw, syn;
  logic             csn_s, sclk_s, mosi_s, scl_s, sda_s;
  ptr_req_t         spi_req, i2c_req, req;
  logic             match_evt;
  logic [6:0]       my_addr;

  assign raw = {spi_csn, spi_sclk, spi_mosi, i2c_scl, i2c_sda};

  sri_sync #(.N(NSYNC), .RST(5'b10011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  assign {csn_s, sclk_s, mosi_s, scl_s, sda_s} = syn;

  sri_spi u_spi (
    .clk(clk), .rst_n(rst_n), .en(~use_i2c), .csn_s(csn_s), .sclk_s(sclk_s),
    .mosi_s(mosi_s), .rdata(reg_rdata), .req(spi_req), .miso(spi_miso),
    .miso_oe(spi_miso_oe));

  sri_alock u_alock (
    .clk(clk), .rst_n(rst_n), .pin_code(addr_pin), .match_evt(match_evt),
    .my_addr(my_addr));

  sri_i2c u_i2c (
    .clk(clk), .rst_n(rst_n), .en(use_i2c), .scl_s(scl_s), .sda_s(sda_s),
    .rdata(reg_rdata), .my_addr(my_addr), .req(i2c_req), .match_evt(match_evt),
    .sda_low(i2c_sda_low));

  assign req = use_i2c ? i2c_req : spi_req;

  sri_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .req(req), .ptr(reg_addr));

  assign reg_we    = req.wr;
  assign reg_wdata = req.wdata;
  assign reg_re    = req.rd;

  assert_port_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  assert_i2c_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_i2c && !$past(use_i2c)) |-> !i2c_sda_low);
endmodule

// File: tb/tb_sri_top.sv
`timescale 1ns/1ps
module tb_sri_top;
  logic clk = 1'b0, rst_n = 1'b0, use_i2c = 1'b1;
  logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_pin = 2'd0;
  logic spi_miso, spi_miso_oe, i2c_sda_low, reg_we, reg_re;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  logic [7:0] model_mem [128];
  logic [14:0] exp_q [$];
  int n_chk = 0, n_fail = 0;
  wire sda_line = sda_m & ~i2c_sda_low;

  always #2.5 clk = ~clk;

  sri_top dut (
    .clk(clk), .rst_n(rst_n), .use_i2c(use_i2c), .spi_csn(spi_csn),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .i2c_scl(scl_m), .i2c_sda(sda_line),
    .i2c_sda_low(i2c_sda_low), .addr_pin(addr_pin), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
    end else if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: every write strobe must match the next write the model expects
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) chk(0, "R12 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, use_i2c ? "R7 write" : "R2 write",
            {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic expect_wr(input logic [6:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    model_mem[a] = d;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; #40 scl_m = 1'b1; #40 sda_m = 1'b0; #40 scl_m = 1'b0; #40;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #40 scl_m = 1'b1; #40 sda_m = 1'b1; #80;
  endtask

  task automatic i2c_wr(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #40 scl_m = 1'b1; #40 scl_m = 1'b0;
    end
    sda_m = 1'b1; #40 scl_m = 1'b1; #20 ack = ~sda_line; #20 scl_m = 1'b0;
  endtask

  task automatic i2c_rd(input bit nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #40 scl_m = 1'b1; #20 d[i] = sda_line; #20 scl_m = 1'b0;
    end
    sda_m = nack; #40 scl_m = 1'b1; #40 scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i]; #40 spi_sclk = 1'b1; rx[i] = spi_miso; #40 spi_sclk = 1'b0;
    end
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 128; i++) model_mem[i] = 8'h00;
    #23 rst_n = 1'b1;
    #10;
    // R11 reset state
    chk(reg_addr == 0, "R11 reg_addr", reg_addr, 0);
    chk(!reg_we && !reg_re, "R11 strobes", {reg_we, reg_re}, 0);
    chk(!spi_miso_oe, "R11 miso_oe", spi_miso_oe, 0);
    chk(!i2c_sda_low, "R11 sda_low", i2c_sda_low, 0);

    // first matching transaction, live strap 0 -> 0x48 (R5, R7)
    i2c_start(); i2c_wr({7'h48, 1'b0}, ack); chk(ack, "R5 ack 0x48", ack, 1);
    i2c_wr(8'h10, ack); chk(ack, "R7 ptr ack", ack, 1);
    expect_wr(7'h10, 8'hA1); i2c_wr(8'hA1, ack); chk(ack, "R7 data ack", ack, 1);
    expect_wr(7'h11, 8'hB2); i2c_wr(8'hB2, ack);
    expect_wr(7'h12, 8'hC3); i2c_wr(8'hC3, ack);
    i2c_stop();

    // strap moved before the second match: live value used (R9, R6)
    addr_pin = 2'd2;
    i2c_start(); i2c_wr({7'h48, 1'b0}, ack); chk(!ack, "R6 nack old address", ack, 0);
    i2c_stop();
    i2c_start(); i2c_wr({7'h4B, 1'b0}, ack); chk(ack, "R9 live strap 0x4B", ack, 1);
    i2c_wr(8'h20, ack);
    expect_wr(7'h20, 8'h5C); i2c_wr(8'h5C, ack);
    i2c_stop();

    // strap frozen: new pin value ignored (R9)
    addr_pin = 2'd0;
    i2c_start(); i2c_wr({7'h48, 1'b0}, ack); chk(!ack, "R9 strap change ignored", ack, 0);
    i2c_stop();
    addr_pin = 2'd1;
    i2c_start(); i2c_wr({7'h4A, 1'b0}, ack); chk(!ack, "R9 code1 ignored", ack, 0);
    i2c_stop();
    // pointer set, repeated START into read (R10, R8)
    i2c_start(); i2c_wr({7'h4B, 1'b0}, ack); chk(ack, "R9 frozen 0x4B", ack, 1);
    i2c_wr(8'h10, ack);
    i2c_start(); i2c_wr({7'h4B, 1'b1}, ack); chk(ack, "R10 repeated start ack", ack, 1);
    i2c_rd(1'b0, d); chk(d == model_mem[7'h10], "R8 read byte0", d, model_mem[7'h10]);
    i2c_rd(1'b1, d); chk(d == model_mem[7'h11], "R8 read byte1", d, model_mem[7'h11]);
    i2c_stop();
    chk(!i2c_sda_low, "R10 released after stop", i2c_sda_low, 0);
    i2c_start(); i2c_wr({7'h4B, 1'b1}, ack);
    i2c_rd(1'b1, d); chk(d == model_mem[7'h12], "R8 pointer kept", d, model_mem[7'h12]);
    i2c_stop();

    // SPI in I2C mode is ignored (R12)
    spi_csn = 1'b0; #40;
    chk(!spi_miso_oe, "R12 spi idle in i2c mode", spi_miso_oe, 0);
    spi_byte(8'h05, d); spi_byte(8'hFF, d);
    #40 spi_csn = 1'b1; #80;

    // SPI mode
    use_i2c = 1'b0; #80;
    i2c_start(); i2c_wr({7'h4B, 1'b0}, ack); chk(!ack, "R12 i2c ignored in spi mode", ack, 0);
    i2c_stop();

    spi_csn = 1'b0; #40;
    chk(spi_miso_oe, "R4 oe in frame", spi_miso_oe, 1);
    spi_byte(8'h05, d);
    expect_wr(7'h05, 8'h33); spi_byte(8'h33, d);
    expect_wr(7'h06, 8'h44); spi_byte(8'h44, d);
    #40 spi_csn = 1'b1; #80;
    chk(!spi_miso_oe, "R4 hiz after cs", spi_miso_oe, 0);

    spi_csn = 1'b0; #40;
    spi_byte(8'h85, d);
    spi_byte(8'h00, d); chk(d == model_mem[7'h05], "R3 spi read byte0", d, model_mem[7'h05]);
    spi_byte(8'h00, d); chk(d == model_mem[7'h06], "R3 spi read byte1", d, model_mem[7'h06]);
    #40 spi_csn = 1'b1; #80;

    spi_csn = 1'b0; #40;
    spi_byte(8'h90, d);
    spi_byte(8'h00, d); chk(d == model_mem[7'h10], "R1 shared pointer read", d, model_mem[7'h10]);
    #40 spi_csn = 1'b1; #80;

    chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    chk(mem[7'h06] == 8'h44, "R2 regfile content", mem[7'h06], 8'h44);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule